// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register accesses to an external PHY over a two-wire management bus. It drives the clock line (MDC) from a divided system clock and drives the data line (MDIO) through an enable/value pair. The enable lets the block release the line when the PHY is expected to answer. A client presents a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit word. The block serialises the frame and returns either read data or an error flag, together with a one-cycle done pulse.

Each frame opens with a long run of ones. Next come the start pattern and the opcode, then both addresses. A write goes on with a driven turnaround and the data word. A read releases the line and checks that the PHY pulls the turnaround bit low. If the PHY does not, the block clocks a flush window and reports an error. Every frame ends with one released idle clock before done.

The sequencer states are `S_IDLE`, `S_PRE`, `S_CMD`, `S_WR`, `S_RTA`, `S_RDAT`, `S_FLUSH`, `S_TAIL` and `S_FIN`. The transitions are:
- `S_IDLE` goes to `S_PRE` on an accepted request.
- `S_PRE` goes to `S_CMD` after 32 bits.
- `S_CMD` goes to `S_WR` (write) or to `S_RTA` (read) after 14 bits.
- `S_WR` goes to `S_TAIL` after 18 bits.
- `S_RTA` goes to `S_RDAT` if the sampled bit is 0, and to `S_FLUSH` if it is 1.
- `S_RDAT` goes to `S_TAIL` after 16 bits.
- `S_FLUSH` goes to `S_TAIL` after 32 bits.
- `S_TAIL` goes to `S_FIN` after 1 bit.
- `S_FIN` goes to `S_IDLE` unconditionally.

Each bit ends when MDC falls, and all transitions other than `S_FIN` to `S_IDLE` are taken at that point.

Top module: `mdio_mgmt_master`

## Requirements
- R1: `req_ready` is high only in idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The operation, the addresses and the write word are captured at that edge, so later changes to the request inputs have no effect on the frame.
- R2: After reset and whenever idle, `mdc` is 0, `mdio_oe` is 0 and `rsp_done` is 0.
- R3: A frame begins with 32 MDC cycles in which MDIO is driven to 1.
- R4: The next four driven bits are 0, 1 (start), then opcode 1,0 for a read or 0,1 for a write.
- R5: The PHY address (5 bits) and then the register address (5 bits) follow, each sent most significant bit first.
- R6: A write keeps MDIO driven and sends 1, 0, then the 16 data bits most significant bit first.
- R7: A read releases MDIO right after the register address and samples one turnaround bit. If that bit is 0, 16 bits are sampled most significant bit first into `rsp_rdata` (first bit lands in bit 15).
- R8: If the read turnaround bit is 1, the block clocks 32 further released MDC cycles, sets `rsp_err`, and returns `rsp_rdata` = 0.
- R9: Every frame ends with one extra MDC cycle with MDIO released. `rsp_done` rises in the same cycle that this cycle's MDC falls. A write frame has 65 MDC cycles, a good read 64 and a failed read 80.
- R10: The MDC low phase lasts at least `LO_CYC` = ceil(CLK_HZ·MDC_LO_NS/1e9) clocks, which is 32 at default. The high phase lasts at least `HI_CYC`, which is 44 at default, so a 350 ns sample delay is met. MDIO and its enable change only when MDC falls, and read bits are sampled in the last clock of the high phase.
- R11: `rsp_done` lasts one clock. `rsp_err` is valid with `rsp_done`, holds while idle, and is 0 from the cycle after the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data of the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Read turnaround failure |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_o | output | 1 | MDIO value when enabled |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench samples every output half a clock after each edge and detects each MDC rise at the first such sample. It records MDIO and its enable at that point and answers as a PHY by changing `mdio_i` there. The design only reads `mdio_i` 44 clocks later, at the end of the high phase.

`rsp_done` is expected at the exact sample where the final MDC fall is first seen, and to be gone one sample later. `rsp_err` is expected clear at the first sample after the accepting edge. Frame lengths are checked as counts of MDC rises, and phase lengths as counts of samples between MDC transitions.

// File: rtl/mdio_m_pkg.sv
package mdio_m_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE, S_CMD, S_WR, S_RTA, S_RDAT, S_FLUSH, S_TAIL, S_FIN
    } mdio_state_t;

    localparam int PRE_BITS   = 32;
    localparam int FLUSH_BITS = 32;
    localparam int TA_BITS    = 2;

    // ceiling of hz * ns / 1e9
    function automatic int ns_to_cyc(input longint hz, input int ns);
        return int'((hz * longint'(ns) + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int LO_CYC = 32,
    parameter int HI_CYC = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_end
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign bit_end = run && mdc && (cnt == CW'(HI_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!mdc) begin
            if (cnt == CW'(LO_CYC - 1)) begin
                cnt <= '0;
                mdc <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == CW'(HI_CYC - 1)) begin
                cnt <= '0;
                mdc <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: phases never end early
    a_r10_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && cnt != CW'(HI_CYC - 1)) |=> mdc);
    a_r10_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !mdc && cnt != CW'(LO_CYC - 1)) |=> !mdc);

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (shift)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_m_pkg::*;
#(
    parameter longint CLK_HZ    = 125_000_000,
    parameter int     MDC_LO_NS = 250,
    parameter int     MDC_HI_NS = 350,
    parameter int     ADDR_W    = 5,
    parameter int     DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              mdc,
    output logic              mdio_oe,
    output logic              mdio_o,
    input  logic              mdio_i
);
    localparam int LO_CYC   = ns_to_cyc(CLK_HZ, MDC_LO_NS);
    localparam int HI_CYC   = ns_to_cyc(CLK_HZ, MDC_HI_NS);
    localparam int CMD_BITS = 4 + 2 * ADDR_W;
    localparam int WR_BITS  = TA_BITS + DATA_W;
    localparam int TX_W     = CMD_BITS + WR_BITS;
    localparam int CNT_W    = $clog2(FLUSH_BITS + 1);

    mdio_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  seg_last;
    logic [TX_W-1:0]   tx_sr;
    logic              rd_op;
    logic              err_q;
    logic              bit_end;
    logic              accept;
    logic              run;
    logic              seg_done;
    mdio_state_t       seg_next;

    assign accept   = req_valid && (state == S_IDLE);
    assign run      = (state != S_IDLE) && (state != S_FIN);
    assign seg_done = bit_end && (bit_cnt == seg_last);

    mdio_mdc_gen #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(run), .mdc(mdc), .bit_end(bit_end)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .shift(bit_end && state == S_RDAT), .din(mdio_i), .q(rsp_rdata)
    );

    // length of the current segment and where it leads
    always_comb begin
        seg_last = '0;
        seg_next = S_IDLE;
        unique case (state)
            S_PRE:   begin seg_last = CNT_W'(PRE_BITS - 1);   seg_next = S_CMD; end
            S_CMD:   begin seg_last = CNT_W'(CMD_BITS - 1);   seg_next = rd_op ? S_RTA : S_WR; end
            S_WR:    begin seg_last = CNT_W'(WR_BITS - 1);    seg_next = S_TAIL; end
            S_RTA:   begin seg_last = '0;                     seg_next = mdio_i ? S_FLUSH : S_RDAT; end
            S_RDAT:  begin seg_last = CNT_W'(DATA_W - 1);     seg_next = S_TAIL; end
            S_FLUSH: begin seg_last = CNT_W'(FLUSH_BITS - 1); seg_next = S_TAIL; end
            S_TAIL:  begin seg_last = '0;                     seg_next = S_FIN; end
            S_IDLE, S_FIN: begin seg_last = '0;               seg_next = S_IDLE; end
            default: begin seg_last = '0;                     seg_next = S_IDLE; end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rd_op   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        state   <= S_PRE;
                        bit_cnt <= '0;
                        rd_op   <= req_rd;
                        err_q   <= 1'b0;
                        tx_sr   <= {2'b01, (req_rd ? 2'b10 : 2'b01),
                                    req_phy, req_reg, 2'b10, req_wdata};
                    end
                end
                S_FIN: state <= S_IDLE;
                default: begin
                    if (bit_end) begin
                        if (state == S_CMD || state == S_WR)
                            tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
                        if (state == S_RTA)
                            err_q <= mdio_i;
                        if (seg_done) begin
                            bit_cnt <= '0;
                            state   <= seg_next;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state)
            S_PRE:        begin mdio_oe = 1'b1; mdio_o = 1'b1; end
            S_CMD, S_WR:  begin mdio_oe = 1'b1; mdio_o = tx_sr[TX_W-1]; end
            default:      begin mdio_oe = 1'b0; mdio_o = 1'b0; end
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign rsp_done  = (state == S_FIN);
    assign rsp_err   = err_q;

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mdc && !mdio_oe && !rsp_done));
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !req_ready);
    a_r10_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    a_r9_tail_released: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!mdio_oe && $past(!mdio_oe)));
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !rsp_err);

endmodule

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_rd = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done, rsp_err, mdc, mdio_oe, mdio_o;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    localparam int EXP_LO = 32;   // ceil(250 ns / 8 ns)
    localparam int EXP_HI = 44;   // ceil(350 ns / 8 ns)

    logic rec_oe [0:127];
    logic rec_o  [0:127];
    int   nrise, min_lo, min_hi, hold_viol, done_on_fall, done_len, seen_busy;
    logic err_at_done;

    always #4 clk = ~clk;

    mdio_mgmt_master u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rd(req_rd), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .mdc(mdc), .mdio_oe(mdio_oe), .mdio_o(mdio_o), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected {oe,o} at MDC rise k
    function automatic logic [1:0] exp_bit(input logic rd, input int k,
            input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        if (k < 32)  return 2'b11;
        if (k == 32) return 2'b10;
        if (k == 33) return 2'b11;
        if (k == 34) return {1'b1, rd};
        if (k == 35) return {1'b1, ~rd};
        if (k <= 40) return {1'b1, phy[40-k]};
        if (k <= 45) return {1'b1, rg[45-k]};
        if (rd)      return 2'b00;
        if (k == 46) return 2'b11;
        if (k == 47) return 2'b10;
        if (k <= 63) return {1'b1, wd[63-k]};
        return 2'b00;
    endfunction

    // issue one request and act as the PHY until done
    task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic ta);
        logic prev, po, poe;
        int lo_run, hi_run, ncyc;
        @(negedge clk);
        req_valid = 1'b1; req_rd = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_rd = ~rd; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;  // R1 latched
        chk(req_ready == 1'b0, "R1 ready low after accept", req_ready, 0);
        chk(rsp_err == 1'b0, "R11 err cleared on accept", rsp_err, 0);
        nrise = 0; min_lo = 1000; min_hi = 1000; hold_viol = 0;
        done_on_fall = 0; done_len = 0; seen_busy = 0; err_at_done = 1'b0;
        lo_run = 1; hi_run = 0; ncyc = 0; prev = mdc; po = mdio_o; poe = mdio_oe;
        mdio_i = 1'b1;
        while (ncyc < 20000) begin
            @(negedge clk);
            ncyc++;
            if (!req_ready) seen_busy++;
            if (mdc && !prev) begin
                if (lo_run < min_lo) min_lo = lo_run;
                lo_run = 0;
                if (nrise < 128) begin
                    rec_oe[nrise] = mdio_oe; rec_o[nrise] = mdio_o;
                end
                if (rd && nrise == 46)                          mdio_i = ta;
                else if (rd && !ta && nrise >= 47 && nrise <= 62) mdio_i = wd[62-nrise];
                else                                            mdio_i = 1'b1;
                nrise++;
            end
            if (!mdc && prev) begin
                if (hi_run < min_hi) min_hi = hi_run;
                hi_run = 0;
            end
            if (mdc && prev && (mdio_o != po || mdio_oe != poe)) hold_viol++;
            if (mdc) hi_run++; else lo_run++;
            if (rsp_done) begin
                done_on_fall = (prev && !mdc) ? 1 : 0;
                err_at_done  = rsp_err;
                done_len = 1;
                prev = mdc;
                break;
            end
            prev = mdc; po = mdio_o; poe = mdio_oe;
        end
        @(negedge clk);
        if (rsp_done) done_len++;
        mdio_i = 1'b1;
    endtask

    task automatic check_bits(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] wd, input int upto);
        int bad3 = 0, bad4 = 0, bad5 = 0, bad6 = 0, bad7 = 0;
        for (int k = 0; k < upto && k < 128; k++) begin
            logic [1:0] e;
            logic mism;
            e = exp_bit(rd, k, phy, rg, wd);
            mism = (rec_oe[k] != e[1]) || (e[1] && rec_o[k] != e[0]);
            if (mism) begin
                if (k < 32) bad3++;
                else if (k < 36) bad4++;
                else if (k < 46) bad5++;
                else if (!rd) bad6++;
                else bad7++;
            end
        end
        chk(bad3 == 0, "R3 preamble bits", bad3, 0);
        chk(bad4 == 0, "R4 start/opcode bits", bad4, 0);
        chk(bad5 == 0, "R5 address bits", bad5, 0);
        if (!rd) chk(bad6 == 0, "R6 turnaround/data bits", bad6, 0);
        else     chk(bad7 == 0, "R7 released after address", bad7, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
        chk(mdc == 1'b0, "R2 mdc low after reset", mdc, 0);
        chk(mdio_oe == 1'b0, "R2 oe low after reset", mdio_oe, 0);
        chk(rsp_done == 1'b0, "R2 done low after reset", rsp_done, 0);
        chk(rsp_err == 1'b0, "R11 err low after reset", rsp_err, 0);
    endtask

    task automatic t_write;
        run_frame(1'b0, 5'h15, 5'h0A, 16'hA5C3, 1'b0);
        check_bits(1'b0, 5'h15, 5'h0A, 16'hA5C3, 65);
        chk(nrise == 65, "R9 write frame length", nrise, 65);
        chk(rec_oe[64] == 1'b0, "R9 tail released", rec_oe[64], 0);
        chk(done_on_fall == 1, "R9 done with final fall", done_on_fall, 1);
        chk(done_len == 1, "R11 done one cycle", done_len, 1);
        chk(err_at_done == 1'b0, "R11 no err on write", err_at_done, 0);
        chk(min_lo >= EXP_LO, "R10 low phase length", min_lo, EXP_LO);
        chk(min_hi >= EXP_HI, "R10 high phase length", min_hi, EXP_HI);
        chk(hold_viol == 0, "R10 MDIO stable while MDC high", hold_viol, 0);
        chk(seen_busy > 0, "R1 not ready while busy", seen_busy, 1);
        chk(req_ready == 1'b1 && mdio_oe == 1'b0 && mdc == 1'b0,
            "R2 idle after write", {req_ready, mdio_oe, mdc}, 3'b100);
    endtask

    task automatic t_read_ok;
        run_frame(1'b1, 5'h01, 5'h1F, 16'h8E71, 1'b0);
        check_bits(1'b1, 5'h01, 5'h1F, 16'h8E71, 64);
        chk(nrise == 64, "R9 read frame length", nrise, 64);
        chk(rsp_rdata == 16'h8E71, "R7 read data", rsp_rdata, 16'h8E71);
        chk(err_at_done == 1'b0, "R7 no err on good read", err_at_done, 0);
        chk(done_on_fall == 1, "R9 done with final fall (read)", done_on_fall, 1);
        chk(hold_viol == 0, "R10 stable while high (read)", hold_viol, 0);
    endtask

    task automatic t_read_bad;
        run_frame(1'b1, 5'h0C, 5'h03, 16'hFFFF, 1'b1);
        check_bits(1'b1, 5'h0C, 5'h03, 16'hFFFF, 80);
        chk(nrise == 80, "R8 flush frame length", nrise, 80);
        chk(err_at_done == 1'b1, "R8 err with done", err_at_done, 1);
        chk(rsp_rdata == 16'h0000, "R8 no read data", rsp_rdata, 0);
        repeat (5) @(negedge clk);
        chk(rsp_err == 1'b1, "R11 err held while idle", rsp_err, 1);
    endtask

    task automatic t_after_err;
        run_frame(1'b0, 5'h1E, 5'h11, 16'h3C0F, 1'b0);
        check_bits(1'b0, 5'h1E, 5'h11, 16'h3C0F, 65);
        chk(err_at_done == 1'b0, "R11 err cleared by next request", err_at_done, 0);
        chk(rsp_rdata == 16'h0000, "R1 rdata cleared on accept", rsp_rdata, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_write();
        t_read_ok();
        t_read_bad();
        t_after_err();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule